// File: doc/BRIEF.md
# Even-Parity Serial Transceiver

This block is a full-duplex asynchronous serial port that carries bytes between a test controller and a host computer. On the transmit side, a byte offered on a valid/ready handshake goes out as a frame on `txd`. The frame has a low start bit, the eight data bits with the least significant first, an even parity bit and one high stop bit. The line stays high between frames.

On the receive side, `rxd` is first resynchronised through two flops. It is then sampled on a tick that runs at sixteen times the bit rate. A start bit is accepted only if the line is still low at its centre. Each bit is decided by a majority vote of three samples around its centre. The recovered byte is presented for one clock, together with a parity-error flag and a framing-error flag.

An external divider supplies the oversampling tick (for example, 115200 baud × 16 from a 50 MHz clock), so both directions share one rate. Each bit lasts exactly sixteen ticks.

Top module: `uart_par_xcvr`

## Requirements
- R1: A transmitted frame is, in order: start bit at 0, the eight data bits with bit 0 first, the parity bit, and a stop bit at 1. Every bit after the start bit lasts exactly 16 ticks.
- R2: The transmitted parity bit equals the XOR of the eight data bits, so data plus parity always has an even number of ones.
- R3: When no frame is being sent, `txd` is 1 and `tx_ready` is 1.
- R4: A byte is taken when `tx_valid` and `tx_ready` are both 1 on a clock edge. From the next cycle until the frame ends, `tx_ready` is 0 and `txd` shows the start bit. Changes on `tx_data` after acceptance do not alter the frame.
- R5: A well-formed received frame produces exactly one single-cycle `rx_valid` pulse, with the byte on `rx_data` (bit 0 received first) and both error flags at 0.
- R6: If the received data plus parity has an odd number of ones, `rx_par_err` is 1 in the `rx_valid` cycle, and the byte is still delivered.
- R7: If the stop bit is sampled as 0, `rx_frm_err` is 1 in the `rx_valid` cycle. The receiver then waits for the line to return high before it looks for a new start bit, so no extra frame is reported.
- R8: A low pulse on `rxd` shorter than half a bit is rejected as a false start and produces no `rx_valid`.
- R9: Each received bit is the majority of three consecutive tick samples at its centre, so a low or high glitch one tick long inside a bit does not change the decoded value.
- R10: Transmit and receive operate at the same time without affecting each other.
- R11: `rx_par_err` and `rx_frm_err` are never 1 outside an `rx_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at 16× the bit rate |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` and the flags are valid |
| rx_par_err | output | 1 | Parity error for this byte |
| rx_frm_err | output | 1 | Stop bit was low for this byte |

## Verification
A wrong transmit bit counter or shift state shows up on `txd` within one bit time as a misplaced or lengthened bit. The bench decodes the line at bit centres and catches this on the frame it affects. On the receive side, a slip of the sample counter or a wrong state after a false start or a bad stop bit shows up as a corrupted byte, a missing pulse or a spurious `rx_valid`. This happens no later than the end of the next frame, and the scoreboard reports it when the pulse arrives, or when the queue is still holding entries at the end of the run.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int OVS_DEF    = 16;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  // majority of three samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_par.sv
module uart_tx_par
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int OVS    = OVS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int CNT_W   = $clog2(OVS);

  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   cnt;

  // named internal events
  logic accept, bit_end, last_bit;
  assign accept   = tx_valid && !busy;
  assign bit_end  = busy && tick_i && (cnt == CNT_W'(OVS-1));
  assign last_bit = (idx == IDX_W'(FRAME_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      idx  <= '0;
      cnt  <= '0;
    end else if (!busy) begin
      if (accept) begin
        busy <= 1'b1;
        sh   <= {1'b1, ^tx_data, tx_data, 1'b0};
        idx  <= '0;
        cnt  <= '0;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        cnt <= '0;
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sh  <= {1'b1, sh[FRAME_W-1:1]};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign tx_ready = !busy;
  assign txd      = busy ? sh[0] : 1'b1;

  // R3: line high whenever idle
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R4: accepted byte starts a frame with the start bit, ready drops
  a_r4_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!txd && !tx_ready));
  // R1: stop bit is high while it is being sent
  a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_bit) |-> txd);
endmodule

// File: rtl/uart_rx_par.sv
module uart_rx_par
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int OVS    = OVS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_s,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int MID   = OVS / 2;

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         smp;
  logic [BIT_W-1:0]   bitn;
  logic [DATA_W-1:0]  dat;
  logic               par;

  // named internal events
  logic active, centre, bit_val;
  assign active  = (state != RX_IDLE) && (state != RX_HOLD);
  assign centre  = active && tick_i && (cnt == CNT_W'(MID));
  assign bit_val = maj3(smp[1], smp[0], rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      smp        <= '1;
      bitn       <= '0;
      dat        <= '0;
      par        <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      case (state)
        RX_HOLD: if (rx_s) state <= RX_IDLE;
        RX_IDLE: begin
          if (tick_i && !rx_s) begin
            state <= RX_START;
            cnt   <= CNT_W'(1);
          end
        end
        default: begin
          if (tick_i) begin
            cnt <= (cnt == CNT_W'(OVS-1)) ? '0 : cnt + 1'b1;
            if (cnt == CNT_W'(MID-2) || cnt == CNT_W'(MID-1))
              smp <= {smp[0], rx_s};
          end
          if (centre) begin
            case (state)
              RX_START: begin
                if (bit_val) state <= RX_IDLE;
                else begin
                  state <= RX_DATA;
                  bitn  <= '0;
                end
              end
              RX_DATA: begin
                dat <= {bit_val, dat[DATA_W-1:1]};
                if (bitn == BIT_W'(DATA_W-1)) state <= RX_PAR;
                else bitn <= bitn + 1'b1;
              end
              RX_PAR: begin
                par   <= bit_val;
                state <= RX_STOP;
              end
              default: begin
                rx_data    <= dat;
                rx_valid   <= 1'b1;
                rx_par_err <= ^{dat, par};
                rx_frm_err <= !bit_val;
                state      <= bit_val ? RX_IDLE : RX_HOLD;
              end
            endcase
          end
        end
      endcase
    end
  end

  // R11: flags only with a valid pulse
  a_r11_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_par_err || rx_frm_err) |-> rx_valid);
  // R5: valid is a single-cycle pulse
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7: after a framing error, stay parked while the line is low
  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_HOLD && !rx_s) |=> (state == RX_HOLD));
  // R7: a framing error parks the receiver
  a_r7_frm_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frm_err && !rx_s) |-> (state == RX_HOLD));
endmodule

// File: rtl/uart_par_xcvr.sv
module uart_par_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int OVS    = OVS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  logic rx_s;

  uart_tx_par #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
  );

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uart_rx_par #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_s(rx_s),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );
endmodule

// File: tb/uart_par_xcvr_bench.sv
module uart_par_xcvr_bench;
  localparam int BITC = 64;   // clocks per bit: 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err;

  int tests = 0;
  int fails = 0;

  typedef struct packed { logic [7:0] d; logic pe; logic fe; } rx_exp_t;
  rx_exp_t    rxq[$];
  logic [7:0] txq[$];

  always #2 clk = ~clk;   // 250 MHz

  logic [1:0] tdiv = '0;
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd3);
  end

  uart_par_xcvr u_uart_par_xcvr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // transmit driver: offer a byte, push the expected frame
  task automatic tx_send(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    txq.push_back(d);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = ~d;      // R4: later changes must not alter the frame
    chk(!tx_ready, "R4 ready low after accept", tx_ready, 0);
  endtask

  // receive driver: build a frame on rxd, push the expected result
  task automatic rx_send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                         input int glitch_bit);
    logic [10:0] fr;
    fr = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
    rxq.push_back('{d: d, pe: bad_par, fe: bad_stop});
    for (int i = 0; i < 11; i++) begin
      if (i == glitch_bit) begin
        rxd = fr[i];  repeat (30) @(negedge clk);
        rxd = ~fr[i]; repeat (4)  @(negedge clk);
        rxd = fr[i];  repeat (30) @(negedge clk);
      end else begin
        rxd = fr[i];
        repeat (BITC) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (2*BITC) @(negedge clk);
  endtask

  // receive monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        if (rxq.size() == 0) begin
          chk(1'b0, "R8 unexpected rx_valid", rx_data, 0);
        end else begin
          rx_exp_t e;
          e = rxq.pop_front();
          chk(rx_data == e.d, "R5/R9 rx_data", rx_data, e.d);
          chk(rx_par_err == e.pe, "R6 rx_par_err", rx_par_err, e.pe);
          chk(rx_frm_err == e.fe, "R7 rx_frm_err", rx_frm_err, e.fe);
        end
      end
      if (rst_n && !rx_valid && (rx_par_err || rx_frm_err))
        chk(1'b0, "R11 flag without valid", {rx_par_err, rx_frm_err}, 0);
    end
  end

  // transmit monitor: decode txd at bit centres
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !txd) begin
        logic [9:0] bits;
        logic [7:0] e;
        repeat (BITC/2 - 1) @(negedge clk);
        chk(!txd, "R1 start bit", txd, 0);
        for (int i = 0; i < 10; i++) begin
          repeat (BITC) @(negedge clk);
          bits[i] = txd;
        end
        e = (txq.size() != 0) ? txq.pop_front() : 8'h00;
        chk(bits[7:0] == e, "R1/R4 tx data LSB first", bits[7:0], e);
        chk(bits[8] == ^e, "R2 even parity bit", bits[8], ^e);
        chk(bits[9] == 1'b1, "R1 stop bit", bits[9], 1);
        while (!txd) @(negedge clk);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(txd == 1'b1, "R3 txd idle after reset", txd, 1);
    chk(tx_ready == 1'b1, "R3 ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R5 no valid after reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R2 R4: several patterns, back to back
    tx_send(8'hA5);
    tx_send(8'h01);
    tx_send(8'h80);
    tx_send(8'hFF);
    tx_send(8'h00);
    repeat (12*BITC) @(negedge clk);
    chk(txd == 1'b1, "R3 txd idle after frames", txd, 1);
    chk(tx_ready == 1'b1, "R3 ready after frames", tx_ready, 1);

    // R5: clean frames
    rx_send(8'h3C, 0, 0, -1);
    rx_send(8'h81, 0, 0, -1);
    // R6: parity error
    rx_send(8'h5A, 1, 0, -1);
    // R7: framing error, then a clean frame must follow
    rx_send(8'hC3, 0, 1, -1);
    rx_send(8'h7E, 0, 0, -1);
    // R8: short low pulse (quarter bit) must give nothing
    rxd = 1'b0;
    repeat (BITC/4) @(negedge clk);
    rxd = 1'b1;
    repeat (3*BITC) @(negedge clk);
    chk(rxq.size() == 0, "R8 false start rejected", rxq.size(), 0);
    // R9: one-tick glitch in a data bit and in the parity bit
    rx_send(8'h96, 0, 0, 3);
    rx_send(8'h0F, 0, 0, 9);

    // R10: full duplex
    fork
      tx_send(8'h69);
      rx_send(8'hB4, 0, 0, -1);
    join
    repeat (12*BITC) @(negedge clk);

    chk(rxq.size() == 0, "R5 all rx frames delivered", rxq.size(), 0);
    chk(txq.size() == 0, "R10 all tx frames seen", txq.size(), 0);
    finish_run();
  end
endmodule